// File: doc/BRIEF.md
# Single-precision floating-point comparator

This block compares two IEEE 754 single-precision operands and answers one of three questions chosen by a two-bit operation code: is `a` equal to `b`, is `a` strictly below `b`, or is `a` at or below `b`. The answer is a single bit, zero-extended to the integer result width. The block also raises an invalid-operation indication in a five-bit flag vector. The caller merges that vector into its own sticky flags.

Signed zeros compare equal. Negative values are ordered by magnitude. A NaN in either operand gives a result of zero. Equality is a quiet comparison: it raises invalid only for a signaling NaN. Both ordered comparisons raise invalid for any NaN. The logic is combinational. A parameter can add one register stage at the outputs.

Top module: `fcmp_sp`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), the result is 0 for every operation code.
- R2: With operation code 2'b10 (equal), invalid is raised only when at least one operand is a signaling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero). A quiet NaN (fraction bit 22 set) raises nothing.
- R3: With operation codes 2'b00 (less-or-equal) and 2'b01 (less-than), invalid is raised when either operand is a NaN of either kind.
- R4: +0 and -0 compare equal. Less-than between any two zeros is 0, and less-or-equal between them is 1.
- R5: When the sign bits differ and the operands are not both zero, `a` is below `b` exactly when `a` is negative.
- R6: When the sign bits match, the lower 31 bits are compared as unsigned integers, and the ordering is reversed when both operands are negative.
- R7: Operation code 2'b11 gives result 0 and all flags 0.
- R8: Invalid is bit 4 of the 5-bit flag output. Bits 3..0 are always 0. The result is zero above bit 0.
- R9: With OUT_REG=1, the outputs appear one clock after the inputs and are 0 during reset (synchronous, active-low `rst_n`). With OUT_REG=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when OUT_REG=1 |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 2 | 00 less-or-equal, 01 less-than, 10 equal, 11 none |
| a | input | 32 | Left operand |
| b | input | 32 | Right operand |
| result | output | XLEN | Comparison bit, zero-extended |
| fflags | output | 5 | Exception flags; bit 4 is invalid |

## Verification
The bench sweeps every pairing of a set of special values: both zeros, both infinities, the smallest and largest subnormals and normals of each sign, and quiet and signaling NaNs with several payloads. Each pairing runs under all four operation codes with NaNs in either operand position, followed by random pairs. A design that ordered negative numbers as raw integers would call -2 less than -3. A design that treated -0 as below +0 would return 1 for a strict comparison of the two zeros. A design that flagged quiet NaNs on equality, or treated the NaN test as a signaling-only test, would show a wrong flag bit 4. Code 11 must stay silent, and the output stage is checked for its one-cycle latency.

// File: rtl/fcmp_sp_pkg.sv
// Shared types and field helpers for the single-precision comparator.
// Assumes IEEE 754 binary32 layout: sign 31, exponent 30:23, fraction 22:0.
package fcmp_sp_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int FLAG_W = 5;
    localparam int INV_BIT = 4;

    typedef enum logic [1:0] {
        CMP_LE   = 2'b00,
        CMP_LT   = 2'b01,
        CMP_EQ   = 2'b10,
        CMP_NONE = 2'b11
    } cmp_op_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic sign;
    } fp_class_t;
endpackage

// File: rtl/fcmp_sp_classify.sv
// Classifies one binary32 operand into NaN / signaling NaN / zero / sign.
// Assumes nothing about the operand; all bit patterns are legal inputs.
module fcmp_sp_classify
    import fcmp_sp_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fp_class_t       cls
);
    logic exp_ones;
    logic frac_nz;

    // decode the exponent and fraction fields into class bits
    always_comb begin
        exp_ones    = &val[FP_W-2 -: EXP_W];
        frac_nz     = |val[FRAC_W-1:0];
        cls.sign    = val[FP_W-1];
        cls.is_nan  = exp_ones && frac_nz;
        cls.is_snan = exp_ones && frac_nz && !val[FRAC_W-1];
        cls.is_zero = ~|val[FP_W-2:0];
    end
endmodule

// File: rtl/fcmp_sp_core.sv
// Combinational compare: computes equal / less-than / less-or-equal
// and the invalid indication for the selected operation code.
// Assumes the classifier outputs belong to the same a and b.
module fcmp_sp_core
    import fcmp_sp_pkg::*;
(
    input  logic [1:0]      op,
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  fp_class_t       ca,
    input  fp_class_t       cb,
    output logic            res,
    output logic            inv
);
    logic any_nan, any_snan, both_zero, mag_lt, mag_eq;
    logic eq_v, lt_v, le_v;

    // raw magnitude relations on the lower 31 bits
    always_comb begin
        mag_lt = a[FP_W-2:0] < b[FP_W-2:0];
        mag_eq = a[FP_W-2:0] == b[FP_W-2:0];
    end

    // ordering relations for non-NaN operands
    always_comb begin
        any_nan   = ca.is_nan || cb.is_nan;
        any_snan  = ca.is_snan || cb.is_snan;
        both_zero = ca.is_zero && cb.is_zero;
        eq_v = both_zero || (ca.sign == cb.sign && mag_eq);
        if (ca.sign != cb.sign)
            lt_v = ca.sign && !both_zero;
        else
            lt_v = !mag_eq && (ca.sign ? !mag_lt : mag_lt);
        le_v = lt_v || eq_v;
    end

    // select by operation code and apply NaN rules
    always_comb begin
        unique case (cmp_op_e'(op))
            CMP_LE:  begin res = !any_nan && le_v; inv = any_nan;  end
            CMP_LT:  begin res = !any_nan && lt_v; inv = any_nan;  end
            CMP_EQ:  begin res = !any_nan && eq_v; inv = any_snan; end
            default: begin res = 1'b0;             inv = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/fcmp_sp.sv
// Top of the single-precision comparator. Builds result and flag vectors
// and optionally registers them (OUT_REG=1) with synchronous active-low reset.
// Assumes XLEN >= 1.
module fcmp_sp
    import fcmp_sp_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op,
    input  logic [FP_W-1:0]   a,
    input  logic [FP_W-1:0]   b,
    output logic [XLEN-1:0]   result,
    output logic [FLAG_W-1:0] fflags
);
    fp_class_t ca, cb;
    logic res_c, inv_c;
    logic [XLEN-1:0]   result_c;
    logic [FLAG_W-1:0] flags_c;

    fcmp_sp_classify u_cls_a (.val(a), .cls(ca));
    fcmp_sp_classify u_cls_b (.val(b), .cls(cb));

    fcmp_sp_core u_core (
        .op(op), .a(a), .b(b), .ca(ca), .cb(cb), .res(res_c), .inv(inv_c)
    );

    // widen the result bit and place invalid in the flag vector
    always_comb begin
        result_c = '0;
        result_c[0] = res_c;
        flags_c = '0;
        flags_c[INV_BIT] = inv_c;
    end

    generate
        if (OUT_REG) begin : g_reg
            // one-cycle output stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result <= '0;
                    fflags <= '0;
                end else begin
                    result <= result_c;
                    fflags <= flags_c;
                end
            end
        end else begin : g_comb
            // direct pass-through
            always_comb begin
                result = result_c;
                fflags = flags_c;
            end
        end
    endgenerate

    // a NaN never produces a true result
    assert_nan_false_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ca.is_nan || cb.is_nan) |-> !res_c);
    // quiet NaNs never flag an equality
    assert_eq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CMP_EQ && !ca.is_snan && !cb.is_snan) |-> !inv_c);
    // ordered comparisons flag every NaN
    assert_ord_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op[1] == 1'b0 && (ca.is_nan || cb.is_nan)) |-> inv_c);
    // two zeros are never strictly ordered
    assert_zero_lt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CMP_LT && ca.is_zero && cb.is_zero) |-> !res_c);
    // unused code stays silent
    assert_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CMP_NONE) |-> (!res_c && !inv_c));
    // only flag bit 4 and result bit 0 can be set
    assert_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fflags[3:0] == 4'b0) && (result[XLEN-1:1] == '0 || XLEN == 1));
    generate
        if (OUT_REG) begin : g_lat
            // registered outputs follow inputs by one cycle
            assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (result[0] == $past(res_c) && fflags[INV_BIT] == $past(inv_c)));
        end
    endgenerate
endmodule

// File: tb/sim_fcmp_sp.sv
// Bench: sweeps special-value pairs under every operation code, then random pairs.
module sim_fcmp_sp;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] op = 0;
    logic [31:0] a = 0, b = 0;
    logic [XLEN-1:0] result;
    logic [4:0] fflags;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_sp #(.XLEN(XLEN), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
        .result(result), .fflags(fflags)
    );

    logic [31:0] specials [0:21];
    initial begin
        specials[0]  = 32'h0000_0000; specials[1]  = 32'h8000_0000;
        specials[2]  = 32'h7F80_0000; specials[3]  = 32'hFF80_0000;
        specials[4]  = 32'h0000_0001; specials[5]  = 32'h8000_0001;
        specials[6]  = 32'h007F_FFFF; specials[7]  = 32'h807F_FFFF;
        specials[8]  = 32'h0080_0000; specials[9]  = 32'h8080_0000;
        specials[10] = 32'h3F80_0000; specials[11] = 32'hBF80_0000;
        specials[12] = 32'h4000_0000; specials[13] = 32'hC000_0000;
        specials[14] = 32'h7F7F_FFFF; specials[15] = 32'hFF7F_FFFF;
        specials[16] = 32'h7FC0_0000; specials[17] = 32'hFFC0_0001;
        specials[18] = 32'h7F80_0001; specials[19] = 32'hFFA0_0000;
        specials[20] = 32'h4040_0000; specials[21] = 32'hC040_0000;
    end

    // reference helpers: arithmetic from field values, no bit tricks shared with RTL
    function automatic bit r_nan(input logic [31:0] v);
        return v[30:23] == 8'd255 && v[22:0] != 0;
    endfunction
    function automatic bit r_snan(input logic [31:0] v);
        return r_nan(v) && v[22] == 1'b0;
    endfunction
    // signed magnitude key: zeros map to 0, negatives negated
    function automatic longint r_key(input logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    task automatic check_one(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        bit er, ei; string rq;
        longint kx, ky;
        kx = r_key(x); ky = r_key(y);
        er = 0; ei = 0;
        if (o == 2'b11) begin er = 0; ei = 0; rq = "R7"; end
        else if (r_nan(x) || r_nan(y)) begin
            er = 0;
            ei = (o == 2'b10) ? (r_snan(x) || r_snan(y)) : 1'b1;
            rq = (o == 2'b10) ? "R1/R2" : "R1/R3";
        end else begin
            case (o)
                2'b00: er = kx <= ky;
                2'b01: er = kx < ky;
                default: er = kx == ky;
            endcase
            rq = (x[30:0] == 0 && y[30:0] == 0) ? "R4" : (x[31] != y[31]) ? "R5" : "R6";
        end
        op = o; a = x; b = y;
        @(posedge clk); #1;
        n_cmp++;
        if (result !== {{(XLEN-1){1'b0}}, er} || fflags !== {ei, 4'b0}) begin
            n_bad++;
            $display("FAIL %s R8 R9 op=%b a=%h b=%h got res=%h flg=%b exp res=%0d flg=%b",
                     rq, o, x, y, result, fflags, er, {ei, 4'b0});
        end
    endtask

    initial begin
        // reset state (R9)
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (result !== '0 || fflags !== '0) begin
            n_bad++;
            $display("FAIL R9 reset got res=%h flg=%b exp 0 0", result, fflags);
        end
        rst_n = 1;
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 22; i++)
                for (int j = 0; j < 22; j++)
                    check_one(2'(o), specials[i], specials[j]);
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] x, y;
            x = $urandom; y = $urandom;
            if (k % 4 == 1) y = {~x[31] & x[31], x[30:0] ^ 31'(k & 3)};
            if (k % 4 == 2) y = {x[31], x[30:8], y[7:0]};
            check_one(2'($urandom_range(0, 3)), x, y);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule